// File: doc/BRIEF.md
# Golay Word Fast Corrector (single and adjacent errors)

This block sits on the read path of a memory whose 24-bit words are protected by the (24,12) extended Golay code. In the stored word, check bits and data bits alternate: every even word index holds a check bit and every odd index holds a data bit. From one stored word the block computes the 12-bit syndrome and repairs the common error shapes in the same cycle. These are any single flipped bit, any two flipped neighbours, and any three flipped neighbours whose middle bit is a data bit. It returns the 12 repaired data bits and two flags. One flag says a repair was made. The other says the word has an error this stage cannot repair, so a slower full decoder must take the word.

Because the bits are interleaved, each data bit needs only one comparator. That comparator ignores the two syndrome bits that belong to the data bit's neighbouring check bits. With one comparator per check bit, the block uses 24 comparators in total. The whole syndrome still takes part in every decision. As a result, a weight-3 error outside the repairable set never causes a wrong repair, and a weight-4 error is always flagged.

A parameter chooses between a purely combinational output and a registered output with one cycle of latency. The registered output is the default.

Top module: `golay_sdaec_dec`

## Requirements
- R1: A stored word with a zero syndrome returns its data field unchanged, and both flags stay low.
- R2: Word layout: check bit i sits at word index 2i and data bit i at index 2i+1, for i = 0..11. The check bits are p = B·d over GF(2), where B is the symmetric 12x12 extended-Golay matrix given by `golay_col` in the package. Syndrome bit i belongs to check bit i.
- R3: A single flipped data bit is repaired, and the repaired flag is raised.
- R4: A single flipped check bit returns the data unchanged, and the repaired flag is raised.
- R5: Every pair of flipped neighbouring bits (23 pairs) is repaired, and the repaired flag is raised.
- R6: Every run of three flipped neighbours centred on a data bit (word indices 2k..2k+2, k = 0..10) is repaired, and the repaired flag is raised.
- R7: A run of three flipped neighbours centred on a check bit raises the uncorrectable flag. The data field passes through exactly as received.
- R8: Any 4-bit error raises the uncorrectable flag, never the repaired flag. The data field passes through exactly as received.
- R9: The two flags are never high together.
- R10: With registered output, out_valid follows in_valid one cycle later. Data and flags change only on cycles where in_valid is high.
- R11: A synchronous active-high reset clears out_valid, the data and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stored word is presented |
| code_in | input | 24 | Stored interleaved word |
| out_valid | output | 1 | Result is valid |
| data_out | output | 12 | Repaired data bits |
| corrected | output | 1 | A repair was made |
| uncorrectable | output | 1 | The word must go to the full decoder |

## Verification
The hardest behaviour to reach from the ports is the boundary between repair and hand-off. Weight-3 runs centred on a check bit, and weight-4 errors, produce syndromes that differ from a repairable one only in the ignored bits, so any masking error would turn them into silent wrong repairs. The stimulus encodes random data with an independent encoder and sweeps every single, adjacent-pair and centred-triple position. It then also sweeps every check-centred triple and random distinct 4-bit patterns. The expected data for these last cases is the raw received field, so any stray flip is caught.

// File: rtl/golay_pkg.sv
package golay_pkg;

   localparam int GOLAY_K = 12;
   localparam int GOLAY_N = 24;

   typedef logic [GOLAY_K-1:0] gvec_t;

   // Column k of the symmetric extended-Golay matrix: bit i is B[i][k].
   function automatic gvec_t golay_col(input int k);
      gvec_t r;
      gvec_t v;
      case (k)
         0:       r = 12'b110111000101;
         1:       r = 12'b101110001011;
         2:       r = 12'b011100010111;
         3:       r = 12'b111000101101;
         4:       r = 12'b110001011011;
         5:       r = 12'b100010110111;
         6:       r = 12'b000101101111;
         7:       r = 12'b001011011101;
         8:       r = 12'b010110111001;
         9:       r = 12'b101101110001;
         10:      r = 12'b011011100011;
         11:      r = 12'b111111111110;
         default: r = '0;
      endcase
      for (int i = 0; i < GOLAY_K; i++) v[i] = r[GOLAY_K-1-i];
      return v;
   endfunction

endpackage

// File: rtl/golay_syndrome.sv
module golay_syndrome
   import golay_pkg::*;
#(
   parameter int DATA_W = 12,
   localparam int WORD_W = 2 * DATA_W
) (
   input  logic [WORD_W-1:0] word,
   output logic [DATA_W-1:0] chk_bits,
   output logic [DATA_W-1:0] dat_bits,
   output logic [DATA_W-1:0] syn
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_split
      assign chk_bits[i] = word[2*i];
      assign dat_bits[i] = word[2*i+1];
   end

   always_comb begin
      logic [DATA_W-1:0] acc;
      acc = chk_bits;
      for (int j = 0; j < DATA_W; j++) begin
         if (dat_bits[j]) acc = acc ^ golay_col(j);
      end
      syn = acc;
   end

endmodule

// File: rtl/golay_match.sv
module golay_match
   import golay_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] syn,
   output logic [DATA_W-1:0] hit_dat,
   output logic [DATA_W-1:0] hit_chk
);

   localparam int LAST = DATA_W - 1;

   // One masked comparator per data bit: the syndrome bits of its
   // neighbouring check bits are ignored.
   for (genvar k = 0; k < DATA_W; k++) begin : g_dat
      localparam logic [DATA_W-1:0] COL = golay_col(k);
      localparam logic [DATA_W-1:0] NEIGH =
         (k == LAST) ? (DATA_W'(1) << k)
                     : ((DATA_W'(1) << k) | (DATA_W'(1) << (k + 1)));
      localparam logic [DATA_W-1:0] MASK = ~NEIGH;
      assign hit_dat[k] = (((syn ^ COL) & MASK) == '0);
   end

   // One full-width comparator per check bit.
   for (genvar i = 0; i < DATA_W; i++) begin : g_chk
      localparam logic [DATA_W-1:0] UNIT = DATA_W'(1) << i;
      assign hit_chk[i] = (syn == UNIT);
   end

endmodule

// File: rtl/golay_fix.sv
module golay_fix #(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] dat_bits,
   input  logic [DATA_W-1:0] syn,
   input  logic [DATA_W-1:0] hit_dat,
   input  logic [DATA_W-1:0] hit_chk,
   output logic [DATA_W-1:0] dat_fix,
   output logic              fixed,
   output logic              give_up
);

   logic any_hit;
   logic nonzero;

   assign any_hit = (|hit_dat) | (|hit_chk);
   assign nonzero = |syn;
   assign dat_fix = dat_bits ^ hit_dat;
   assign fixed   = any_hit;
   assign give_up = nonzero & ~any_hit;

endmodule

// File: rtl/golay_sdaec_dec.sv
module golay_sdaec_dec #(
   parameter int DATA_W  = 12,
   parameter bit REG_OUT = 1'b1,
   localparam int WORD_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] code_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] data_out,
   output logic              corrected,
   output logic              uncorrectable
);

   if (DATA_W != golay_pkg::GOLAY_K) begin : g_bad_width
      $error("golay_sdaec_dec: DATA_W must equal 12");
   end

   logic [DATA_W-1:0] chk_bits;
   logic [DATA_W-1:0] dat_bits;
   logic [DATA_W-1:0] syn;
   logic [DATA_W-1:0] hit_dat;
   logic [DATA_W-1:0] hit_chk;
   logic [DATA_W-1:0] dat_fix;
   logic              fixed;
   logic              give_up;

   golay_syndrome #(.DATA_W(DATA_W)) u_syn (
      .word     (code_in),
      .chk_bits (chk_bits),
      .dat_bits (dat_bits),
      .syn      (syn)
   );

   golay_match #(.DATA_W(DATA_W)) u_match (
      .syn     (syn),
      .hit_dat (hit_dat),
      .hit_chk (hit_chk)
   );

   golay_fix #(.DATA_W(DATA_W)) u_fix (
      .dat_bits (dat_bits),
      .syn      (syn),
      .hit_dat  (hit_dat),
      .hit_chk  (hit_chk),
      .dat_fix  (dat_fix),
      .fixed    (fixed),
      .give_up  (give_up)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            out_valid     <= 1'b0;
            data_out      <= '0;
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               data_out      <= dat_fix;
               corrected     <= fixed;
               uncorrectable <= give_up;
            end
         end
      end
   end else begin : g_comb
      assign out_valid     = in_valid & ~rst;
      assign data_out      = dat_fix;
      assign corrected     = fixed;
      assign uncorrectable = give_up;
   end

   // chk_bits feeds only the syndrome; keep it observed for completeness.
   logic unused_chk;
   assign unused_chk = ^chk_bits;

endmodule

// File: rtl/golay_sdaec_chk.sv
module golay_sdaec_chk #(
   parameter int DATA_W  = 12,
   parameter bit REG_OUT = 1'b1,
   localparam int WORD_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [WORD_W-1:0] code_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] data_out,
   input logic              corrected,
   input logic              uncorrectable
);

   logic [DATA_W-1:0] raw;
   always_comb begin
      for (int i = 0; i < DATA_W; i++) raw[i] = code_in[2*i+1];
   end

   p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !(corrected && uncorrectable));

   if (REG_OUT) begin : g_reg_chk
      p_reset_clear_r11: assert property (@(posedge clk)
         rst |=> (!out_valid && !corrected && !uncorrectable && data_out == '0));

      p_latency_r10: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);

      p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> (!out_valid && $stable(data_out)));

      p_one_flip_r3: assert property (@(posedge clk) disable iff (rst)
         (in_valid && !rst) |=> (!corrected || $countones(data_out ^ $past(raw)) <= 1));

      p_pass_raw_r8: assert property (@(posedge clk) disable iff (rst)
         (in_valid && !rst) |=> (corrected || data_out == $past(raw)));
   end

endmodule

bind golay_sdaec_dec golay_sdaec_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .in_valid      (in_valid),
   .code_in       (code_in),
   .out_valid     (out_valid),
   .data_out      (data_out),
   .corrected     (corrected),
   .uncorrectable (uncorrectable)
);

// File: tb/sim_golay_sdaec_dec.sv
module sim_golay_sdaec_dec;
   import golay_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [23:0] code_in = '0;
   logic        out_valid;
   logic [11:0] data_out;
   logic        corrected;
   logic        uncorrectable;

   int tot = 0;
   int bad = 0;
   bit done = 0;

   typedef struct {
      logic [11:0] data;
      logic        corr;
      logic        unc;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   golay_sdaec_dec u0 (
      .clk           (clk),
      .rst           (rst),
      .in_valid      (in_valid),
      .code_in       (code_in),
      .out_valid     (out_valid),
      .data_out      (data_out),
      .corrected     (corrected),
      .uncorrectable (uncorrectable)
   );

   // Reference encoder (R2 layout).
   function automatic logic [23:0] encode(input logic [11:0] d);
      logic [11:0] p;
      logic [23:0] w;
      p = '0;
      for (int j = 0; j < 12; j++) if (d[j]) p = p ^ golay_col(j);
      for (int i = 0; i < 12; i++) begin
         w[2*i]   = p[i];
         w[2*i+1] = d[i];
      end
      return w;
   endfunction

   function automatic logic [11:0] field(input logic [23:0] w);
      logic [11:0] d;
      for (int i = 0; i < 12; i++) d[i] = w[2*i+1];
      return d;
   endfunction

   task automatic send(input logic [23:0] w, input logic [11:0] ed,
                       input logic ec, input logic eu, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      code_in  = w;
      e.data = ed; e.corr = ec; e.unc = eu; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic check(input bit ok, input string tag,
                        input logic [15:0] act, input logic [15:0] expv);
      tot++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // Monitor: pops the scoreboard whenever a result is presented.
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R10 unexpected out_valid", 16'h1, 16'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(data_out == e.data && corrected == e.corr && uncorrectable == e.unc,
                  e.tag, {2'b0, corrected, uncorrectable, data_out},
                  {2'b0, e.corr, e.unc, e.data});
            check(!(corrected && uncorrectable), "R9 both flags",
                  {14'b0, corrected, uncorrectable}, 16'h0);
         end
      end
   end

   // Watchdog.
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         tot++;
         $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
         $display("test done: total=%0d bad=%0d", tot, bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] d;
      logic [23:0] c;
      logic [23:0] e;
      logic [11:0] last;

      repeat (3) @(negedge clk);
      // R11: reset state
      check(!out_valid && !corrected && !uncorrectable && data_out == '0,
            "R11 reset outputs", {2'b0, corrected, uncorrectable, data_out}, 16'h0);
      @(negedge clk);
      rst = 1'b0;

      for (int n = 0; n < 20; n++) begin
         d = (n == 0) ? 12'h000 : (n == 1) ? 12'hfff : 12'($urandom);
         c = encode(d);
         send(c, d, 1'b0, 1'b0, "R1 R2 clean word");
         for (int b = 0; b < 24; b++) begin
            if (b % 2 == 1) send(c ^ (24'h1 << b), d, 1'b1, 1'b0, "R3 single data bit");
            else            send(c ^ (24'h1 << b), d, 1'b1, 1'b0, "R4 single check bit");
         end
         for (int b = 0; b < 23; b++)
            send(c ^ (24'h3 << b), d, 1'b1, 1'b0, "R5 adjacent pair");
         for (int k = 0; k < 11; k++)
            send(c ^ (24'h7 << (2*k)), d, 1'b1, 1'b0, "R6 data-centred triple");
         for (int k = 1; k < 12; k++) begin
            e = 24'h7 << (2*k - 1);
            send(c ^ e, field(c ^ e), 1'b0, 1'b1, "R7 check-centred triple");
         end
         for (int q = 0; q < 10; q++) begin
            e = '0;
            while ($countones(e) < 4) e[$urandom_range(23, 0)] = 1'b1;
            send(c ^ e, field(c ^ e), 1'b0, 1'b1, "R8 four-bit error");
         end
      end

      // R10: idle cycles leave outputs held.
      @(negedge clk);
      in_valid = 1'b0;
      code_in  = 24'hffffff;
      @(negedge clk);
      last = data_out;
      repeat (2) @(negedge clk);
      check(!out_valid && data_out == last, "R10 idle hold",
            {3'b0, out_valid, data_out}, {4'b0, last});
      check(sb.size() == 0, "R10 all results seen", 16'(sb.size()), 16'h0);

      // R11: reset mid-run clears state.
      send(encode(12'h5a5), 12'h5a5, 1'b0, 1'b0, "R1 clean before reset");
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check(!out_valid && data_out == '0 && !corrected && !uncorrectable,
            "R11 reset clears", {3'b0, out_valid, data_out}, 16'h0);
      rst = 1'b0;
      @(negedge clk);

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", tot, bad);
         $finish;
      end
   end

endmodule